// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes charge of an asynchronous DRAM from reset onward. It first holds every strobe idle for the power-up pause, then drives a short burst of dummy refreshes, and only after that raises `ready`. From then on a free-running interval timer produces refresh demands. Each refresh is a column-before-row cycle: both column strobes fall first, the row strobe follows, and then both rise together. Write enable stays high for the whole cycle. Address and data are not touched.

During normal operation the block shares the memory pins with an access controller. It raises `ref_req` and drives the strobes only after `ref_gnt` is returned. Demands that arrive while the grant is withheld are counted, up to `MAX_PEND`. When the count is full, `ref_urgent` tells the controller to finish its current access and yield. A level request, `self_req`, moves the memory into self refresh. The sequencer runs a bracketing burst of refreshes, then a column-before-row entry with the row strobe held low for at least the minimum self-refresh time. On exit it applies the long self-refresh precharge and runs a second bracketing burst.

All times are derived from `CLK_MHZ`. `TIME_DIV` divides the long intervals (pause, refresh interval, self-refresh minimum) so that a simulation stays short. `LONG_PERIOD` selects the low-power device, whose refresh period is doubled.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset is released, `ras_n` and `cas_n` stay high and `ready` stays low for exactly INIT_CYC = 200*CLK_MHZ/TIME_DIV cycles. The first column-strobe fall appears on the following cycle.
- R2: The power-up burst consists of exactly INIT_REFS refresh cycles, with no grant needed. `ready` rises when the last one completes and never falls afterwards.
- R3: Every refresh is column-before-row. `cas_n` is 2'b00 for CSR_C cycles before `ras_n` falls. `ras_n` stays low RAS_C cycles. `ras_n` and `cas_n` rise together. Within a burst the row strobe stays high RP_C+CSR_C cycles. `we_n` is always 1. Each count is ceil(ns*CLK_MHZ/1000), at least 1.
- R4: With the grant always given, successive refresh row-strobe falls are IVL_CYC = 15600*CLK_MHZ/(1000*TIME_DIV) cycles apart (integer division).
- R5: With LONG_PERIOD=1 the spacing is 31200*CLK_MHZ/(1000*TIME_DIV) cycles.
- R6: Once `ready` is high, the strobes stay idle while `ref_gnt` is low, and `ref_req` is high whenever a refresh is owed.
- R7: Owed refreshes accumulate up to MAX_PEND; further demands are dropped. `ref_urgent` is high exactly while MAX_PEND are owed. On grant, every owed refresh is executed.
- R8: When `self_req` is seen in idle, BRACKET_REFS normal refreshes run, then a column-before-row entry. The sequencer then holds `ras_n` and `cas_n` low with `in_self` high until exit.
- R9: `in_self` lasts at least SELF_CYC = 100*CLK_MHZ/TIME_DIV+1 cycles, even if `self_req` drops earlier. If `self_req` is already low, it lasts exactly SELF_CYC.
- R10: After self refresh the row strobe stays high RPS_C+CSR_C cycles before the next fall. Then BRACKET_REFS refreshes run, after which `ref_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Memory pins handed to the sequencer |
| self_req | input | 1 | Level request to stay in self refresh |
| ref_req | output | 1 | Sequencer needs or holds the memory pins |
| ref_urgent | output | 1 | Owed refresh count is full |
| ready | output | 1 | Power-up sequence complete |
| in_self | output | 1 | Memory is in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Both column strobes, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The hardest condition to reach is a full backlog. It only arises when the grant has been withheld over several interval ticks. The dropped demands can be seen only by counting how many refreshes come out afterwards. The bench finds the tick grid from the cycle on which `ready` rises. It withholds the grant well past the point where the count saturates, then releases it in the middle of an interval. It then counts row-strobe falls over a window that ends clear of any tick, where the count must be MAX_PEND plus the ticks that fell inside the window. Self-refresh exit is reached twice: once with `self_req` held past the minimum, and once with it dropped as soon as `in_self` rises, which isolates the minimum-time guard.

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int CLK_MHZ      = 100,
  parameter int TIME_DIV     = 1,
  parameter int LONG_PERIOD  = 0,
  parameter int INIT_REFS    = 8,
  parameter int BRACKET_REFS = 4096,
  parameter int MAX_PEND     = 8,
  parameter int CSR_NS       = 10,
  parameter int RAS_NS       = 50,
  parameter int RP_NS        = 40,
  parameter int RPS_NS       = 110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_gnt,
  input  logic       self_req,
  output logic       ref_req,
  output logic       ref_urgent,
  output logic       ready,
  output logic       in_self,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       we_n
);
  function automatic int ns2c(input int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int INIT_CYC = (200 * CLK_MHZ) / TIME_DIV;
  localparam int IVL_NS   = (LONG_PERIOD != 0) ? 31200 : 15600;
  localparam int IVL_CYC  = (IVL_NS * CLK_MHZ) / (1000 * TIME_DIV);
  localparam int SELF_CYC = (100 * CLK_MHZ) / TIME_DIV + 1;
  localparam int CSR_C    = ns2c(CSR_NS);
  localparam int RAS_C    = ns2c(RAS_NS);
  localparam int RP_C     = ns2c(RP_NS);
  localparam int RPS_C    = ns2c(RPS_NS);
  localparam int TW = $clog2(INIT_CYC + SELF_CYC + RPS_C + RAS_C + RP_C + CSR_C + 1);
  localparam int IW = $clog2(IVL_CYC + 1);
  localparam int BW = $clog2(((INIT_REFS > BRACKET_REFS) ? INIT_REFS : BRACKET_REFS) + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_REQ, S_CSR, S_RAS, S_PRE, S_SELF, S_SPRE} state_t;
  typedef enum logic [2:0] {P_INIT, P_RUN, P_PRE_SR, P_SELF, P_POST_SR} phase_t;

  state_t        state;
  phase_t        phase;
  logic [TW-1:0] tmr;
  logic [IW-1:0] ivl;
  logic [BW-1:0] left;
  logic [PW-1:0] pend;
  logic          rdy;
  logic          tick, served;

  assign tick   = (phase == P_RUN) && (ivl == IW'(IVL_CYC - 1));
  assign served = (state == S_PRE) && (tmr == '0) && (phase == P_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl  <= '0;
      pend <= '0;
    end else begin
      if (phase != P_RUN || tick) ivl <= '0;
      else                        ivl <= ivl + 1'b1;
      if (tick && pend != PW'(MAX_PEND) && !served) pend <= pend + 1'b1;
      else if (served && !(tick && pend != PW'(MAX_PEND))) pend <= pend - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_PWR;
      phase <= P_INIT;
      tmr   <= TW'(INIT_CYC - 1);
      left  <= BW'(INIT_REFS);
      rdy   <= 1'b0;
    end else begin
      case (state)
        S_PWR: begin
          if (tmr == '0) begin
            state <= S_CSR;
            tmr   <= TW'(CSR_C - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_IDLE: begin
          tmr <= TW'(CSR_C - 1);
          if (self_req) begin
            phase <= (BRACKET_REFS == 0) ? P_SELF : P_PRE_SR;
            left  <= BW'(BRACKET_REFS);
            state <= S_REQ;
          end else if (pend != '0) begin
            state <= ref_gnt ? S_CSR : S_REQ;
          end
        end
        S_REQ: begin
          tmr <= TW'(CSR_C - 1);
          if (ref_gnt) state <= S_CSR;
        end
        S_CSR: begin
          if (tmr == '0) begin
            state <= S_RAS;
            tmr   <= TW'(RAS_C - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_RAS: begin
          if (tmr == '0) begin
            if (phase == P_SELF) begin
              state <= S_SELF;
              tmr   <= TW'(SELF_CYC - 1);
            end else begin
              state <= S_PRE;
              tmr   <= TW'(RP_C - 1);
            end
          end else tmr <= tmr - 1'b1;
        end
        S_PRE: begin
          if (tmr == '0) begin
            tmr   <= TW'(CSR_C - 1);
            state <= S_CSR;
            left  <= left - 1'b1;
            case (phase)
              P_INIT:
                if (left == BW'(1)) begin
                  rdy   <= 1'b1;
                  phase <= P_RUN;
                  state <= S_IDLE;
                end
              P_PRE_SR:
                if (left == BW'(1)) phase <= P_SELF;
              P_POST_SR:
                if (left == BW'(1)) begin
                  phase <= P_RUN;
                  state <= S_IDLE;
                end
              default: begin
                left  <= left;
                state <= S_IDLE;
              end
            endcase
          end else tmr <= tmr - 1'b1;
        end
        S_SELF: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (!self_req) begin
            state <= S_SPRE;
            tmr   <= TW'(RPS_C - 1);
          end
        end
        default: begin
          if (tmr == '0) begin
            tmr <= TW'(CSR_C - 1);
            if (BRACKET_REFS == 0) begin
              phase <= P_RUN;
              state <= S_IDLE;
            end else begin
              phase <= P_POST_SR;
              left  <= BW'(BRACKET_REFS);
              state <= S_CSR;
            end
          end else tmr <= tmr - 1'b1;
        end
      endcase
    end
  end

  assign ras_n      = !(state == S_RAS || state == S_SELF);
  assign cas_n      = {2{!(state == S_CSR || state == S_RAS || state == S_SELF)}};
  assign we_n       = 1'b1;
  assign ready      = rdy;
  assign in_self    = (state == S_SELF);
  assign ref_req    = rdy && (state != S_IDLE || pend != '0);
  assign ref_urgent = (pend == PW'(MAX_PEND));
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
  parameter int SELF_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic       ref_req,
  input logic       ref_gnt,
  input logic       ready,
  input logic       ref_urgent,
  input logic       in_self
);
  int self_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       self_len <= 0;
    else if (in_self) self_len <= self_len + 1;
    else              self_len <= 0;
  end

  a_r3_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(cas_n) == 2'b00);

  a_r3_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n == 2'b11);

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r6_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n[0]) && $past(ready)) |-> $past(ref_gnt));

  a_r7_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);

  a_r8_self_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    in_self |-> (!ras_n && cas_n == 2'b00));

  a_r9_self_minimum: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_self) |-> self_len >= SELF_CYC);
endmodule

bind refresh_sequencer refresh_sequencer_chk #(.SELF_CYC(SELF_CYC)) u_chk (.*);

// File: tb/tb_refresh_sequencer.sv
module tb_refresh_sequencer;
  localparam int MHZ = 100, DIV = 50, NINIT = 8, NBR = 3, NPEND = 3;
  localparam int INIT_CYC = 200 * MHZ / DIV;
  localparam int IVL      = 15600 * MHZ / (1000 * DIV);
  localparam int IVL_LP   = 31200 * MHZ / (1000 * DIV);
  localparam int SELF_CYC = 100 * MHZ / DIV + 1;
  localparam int CSR_C = 1, RAS_C = 5, RP_C = 4, RPS_C = 11;

  logic clk = 0, rst_n = 0, gnt = 0, sreq = 0;
  logic req, urg, rdy, insf, ras_n, we_n;
  logic [1:0] cas_n;
  logic lreq, lurg, lrdy, linsf, lras_n, lwe_n;
  logic [1:0] lcas_n;

  always #5 clk = ~clk;

  refresh_sequencer #(.CLK_MHZ(MHZ), .TIME_DIV(DIV), .INIT_REFS(NINIT),
    .BRACKET_REFS(NBR), .MAX_PEND(NPEND)) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .self_req(sreq), .ref_req(req),
    .ref_urgent(urg), .ready(rdy), .in_self(insf), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  refresh_sequencer #(.CLK_MHZ(MHZ), .TIME_DIV(DIV), .LONG_PERIOD(1), .INIT_REFS(NINIT),
    .BRACKET_REFS(NBR), .MAX_PEND(NPEND)) dut_lp (
    .clk(clk), .rst_n(rst_n), .ref_gnt(1'b1), .self_req(1'b0), .ref_req(lreq),
    .ref_urgent(lurg), .ready(lrdy), .in_self(linsf), .ras_n(lras_n), .cas_n(lcas_n), .we_n(lwe_n));

  int tests = 0, fails = 0;
  int cyc = 0, falls = 0, last_fall = 0, prev_fall = 0;
  int low_run = 0, last_low = 0, high_run = 0, last_gap = 0;
  int self_run = 0, last_self = 0, cbr_bad = 0, we_bad = 0;
  int lp_last = 0, lp_prev = 0;
  logic ras_q = 1, lras_q = 1;
  logic [1:0] cas_q = 2'b11;

  always @(negedge clk) begin
    cyc++;
    if (we_n !== 1'b1 || lwe_n !== 1'b1) we_bad++;
    if (!ras_n && ras_q) begin
      falls++;
      prev_fall = last_fall;
      last_fall = cyc;
      last_gap  = high_run;
      high_run  = 0;
      if (cas_q != 2'b00) cbr_bad++;
    end
    if (ras_n && !ras_q) begin
      last_low = low_run;
      low_run  = 0;
    end
    if (!ras_n) low_run++; else high_run++;
    if (insf) self_run++;
    else if (self_run > 0) begin
      last_self = self_run;
      self_run  = 0;
    end
    if (!lras_n && lras_q) begin
      lp_prev = lp_last;
      lp_last = cyc;
    end
    ras_q  = ras_n;
    cas_q  = cas_n;
    lras_q = lras_n;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic upto(input int c);
    while (cyc < c) tick();
  endtask

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_ge(input string r, input int act, input int lim);
    tests++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s actual=%0d expected>=%0d", r, act, lim);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int n, r0, f0, f1, f2, f3;
    repeat (5) tick();
    chk("R1 reset ras_n", int'(ras_n), 1);
    chk("R1 reset cas_n", int'(cas_n), 3);
    chk("R1 reset ready", int'(rdy), 0);
    chk("R6 reset ref_req", int'(req), 0);
    rst_n = 1;
    n = 0;
    while (cas_n == 2'b11) begin
      tick();
      n++;
    end
    chk("R1 pause length", n, INIT_CYC);
    while (!rdy) tick();
    chk("R2 init burst count", falls, NINIT);
    chk("R3 ras low width", last_low, RAS_C);
    chk("R3 burst precharge gap", last_gap, RP_C + CSR_C);
    r0 = cyc;
    f0 = falls;
    upto(r0 + 3 * IVL - 3);
    chk("R7 urgent before full", int'(urg), 0);
    upto(r0 + 3 * IVL + 3);
    chk("R7 urgent when full", int'(urg), 1);
    upto(r0 + 10 * IVL + 5);
    chk("R6 no refresh without grant", falls - f0, 0);
    chk("R6 request while owed", int'(req), 1);
    chk("R2 ready held", int'(rdy), 1);
    gnt = 1;
    f1 = falls;
    upto(r0 + 20 * IVL + 20);
    chk("R7 drained backlog plus new", falls - f1, NPEND + 10);
    chk("R7 urgent cleared", int'(urg), 0);
    upto(r0 + 23 * IVL + 20);
    chk("R4 refresh spacing", last_fall - prev_fall, IVL);

    while (req) tick();
    sreq = 1;
    f2 = falls;
    while (!insf) tick();
    chk("R8 pre burst plus entry", falls - f2, NBR + 1);
    repeat (SELF_CYC + 40) tick();
    chk("R8 row held in self", int'(ras_n), 0);
    chk("R8 in_self held", int'(insf), 1);
    chk("R8 no extra cycles", falls - f2, NBR + 1);
    sreq = 0;
    while (insf) tick();
    chk_ge("R9 long self time", last_self, SELF_CYC);
    f3 = falls;
    while (falls == f3) tick();
    chk("R10 exit precharge gap", last_gap, RPS_C + CSR_C);
    while (req) tick();
    chk("R10 post burst count", falls - f3, NBR);

    sreq = 1;
    while (!insf) tick();
    sreq = 0;
    while (insf) tick();
    chk("R9 minimum self time", last_self, SELF_CYC);
    chk("R9 row low incl entry", last_low, RAS_C + SELF_CYC);

    chk("R3 column before row", cbr_bad, 0);
    chk("R3 write enable high", we_bad, 0);
    chk("R5 long period spacing", lp_last - lp_prev, IVL_LP);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule